// File: doc/BRIEF.md
# ALU Status Flag Unit

This block turns the outcome of one 8-bit ALU operation into the six status flags a small processor tests and saves: sign, zero, half carry, parity/overflow, subtract and carry. The datapath presents the operation class, both operands, the result it produced and the carry (or borrow) that left bit 7. The block applies the rule set for that class, writes the new flag byte, and shows it on `flags` from the next cycle on.

Two flag bytes are held, the active one and a spare copy. A one-cycle `xchg` pulse swaps them, so an interrupt handler can park the caller's status and get it back later without going through memory. Only the active copy is ever written by an operation.

The operation input is a valid/ready stream whose ready is always high. Every beat with `op_valid` high is taken at that clock edge, and the producer never stalls. Sixteen-bit arithmetic and decimal adjust are handled elsewhere.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low, both flag copies clear to 8'h00 and `flags` reads 8'h00. `op_ready` is high at all times: no back-pressure.
- R2: Layout of `flags`: S bit 7, Z bit 6, H bit 4, P/V bit 2, N bit 1, C bit 0. Bits 5 and 3 always read 0. Codes for `op_class`: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 increment, 6 decrement, 7 rotate/shift, 8 set carry, 9 complement carry, 10 complement accumulator. Codes 11 to 15 are reserved.
- R3: For codes 0 to 7, S takes bit 7 of `result`, and Z is 1 exactly when `result` is zero.
- R4: For AND, OR, XOR and rotate/shift, P/V is 1 when `result` holds an even count of ones.
- R5: For add, subtract, increment and decrement, P/V is 1 when the signed result falls outside -128..+127. Increment and decrement use a step of 1 from `opnd_a`.
- R6: For add, subtract, increment and decrement, H reports the carry or borrow out of bit 3. AND sets H. OR, XOR and rotate/shift clear H.
- R7: C takes `carry_out` for add, subtract and rotate/shift. Logic operations clear C. Increment and decrement keep the previous C.
- R8: N is 1 after subtract, decrement and complement accumulator. N is 0 after add, increment, logic, rotate/shift, set carry and complement carry.
- R9: Set carry gives C=1 and H=0. Complement carry inverts C and loads H with the previous C. Complement accumulator sets H. These three codes keep S, Z and P/V.
- R10: An `xchg` pulse swaps the active and spare copies. If an operation is accepted in the same cycle, it updates the copy that was active, and that copy then becomes the spare.
- R11: A cycle with `op_valid` low, or with a reserved code, leaves both copies unchanged.
- R12: The flags of an operation accepted at clock edge k appear on `flags` right after edge k, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation beat is present |
| op_ready | output | 1 | Always 1; the beat is taken at the edge |
| op_class | input | 4 | Operation class code (R2) |
| opnd_a | input | 8 | First operand (the incremented or decremented value) |
| opnd_b | input | 8 | Second operand |
| result | input | 8 | Result the ALU produced |
| carry_out | input | 1 | Carry or borrow out of bit 7, or the bit shifted out |
| xchg | input | 1 | Swap active and spare flag copies |
| flags | output | 8 | Active flag byte |

## Verification
A wrong bit held in either copy does not stay hidden for long. In the active copy it is on `flags` in the very next cycle. In the spare copy it shows in the cycle after a swap. A wrong carry kept by an increment or decrement, or a wrong carry fed to complement carry, spreads into later flag bytes. The bench therefore compares the whole byte after every cycle of long random runs that mix swaps with operations. It also checks each field under the requirement that owns it, so the first wrong bit is reported in the cycle it appears.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_ROT  = 4'd7,
    OP_SCF  = 4'd8,
    OP_CCF  = 4'd9,
    OP_CPL  = 4'd10
  } fg_op_e;

  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_X5 = 5;
  localparam int FB_H  = 4;
  localparam int FB_X3 = 3;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  localparam int FB_C  = 0;
  localparam int FLAG_W = 8;
endpackage

// File: rtl/fg_parity.sv
module fg_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic         even
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ din[i];
  end
  assign even = ~chain[W];
endmodule

// File: rtl/fg_calc.sv
module fg_calc
  import fg_pkg::*;
#(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic [3:0]        op,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [W-1:0]      r,
  input  logic              co,
  input  logic [FLAG_W-1:0] cur,
  output logic [FLAG_W-1:0] nxt,
  output logic              known
);
  localparam int MSB = W - 1;

  logic even_par;
  logic is_zero;
  logic half_ab;
  logic half_a;
  logic ovf_add;
  logic ovf_sub;

  fg_parity #(.W(W)) u_par (.din(r), .even(even_par));

  assign is_zero = (r == '0);
  assign half_ab = a[HB] ^ b[HB] ^ r[HB];
  assign half_a  = a[HB] ^ r[HB];
  assign ovf_add = (a[MSB] == b[MSB]) && (r[MSB] != a[MSB]);
  assign ovf_sub = (a[MSB] != b[MSB]) && (r[MSB] != a[MSB]);

  always_comb begin
    nxt   = cur;
    known = 1'b1;
    case (op)
      OP_ADD, OP_SUB: begin
        nxt[FB_S]  = r[MSB];
        nxt[FB_Z]  = is_zero;
        nxt[FB_H]  = half_ab;
        nxt[FB_PV] = (op == OP_SUB) ? ovf_sub : ovf_add;
        nxt[FB_N]  = (op == OP_SUB);
        nxt[FB_C]  = co;
      end
      OP_AND, OP_OR, OP_XOR: begin
        nxt[FB_S]  = r[MSB];
        nxt[FB_Z]  = is_zero;
        nxt[FB_H]  = (op == OP_AND);
        nxt[FB_PV] = even_par;
        nxt[FB_N]  = 1'b0;
        nxt[FB_C]  = 1'b0;
      end
      OP_INC, OP_DEC: begin
        nxt[FB_S]  = r[MSB];
        nxt[FB_Z]  = is_zero;
        nxt[FB_H]  = half_a;
        nxt[FB_PV] = (op == OP_INC) ? (!a[MSB] && r[MSB]) : (a[MSB] && !r[MSB]);
        nxt[FB_N]  = (op == OP_DEC);
      end
      OP_ROT: begin
        nxt[FB_S]  = r[MSB];
        nxt[FB_Z]  = is_zero;
        nxt[FB_H]  = 1'b0;
        nxt[FB_PV] = even_par;
        nxt[FB_N]  = 1'b0;
        nxt[FB_C]  = co;
      end
      OP_SCF: begin
        nxt[FB_H] = 1'b0;
        nxt[FB_N] = 1'b0;
        nxt[FB_C] = 1'b1;
      end
      OP_CCF: begin
        nxt[FB_H] = cur[FB_C];
        nxt[FB_N] = 1'b0;
        nxt[FB_C] = ~cur[FB_C];
      end
      OP_CPL: begin
        nxt[FB_H] = 1'b1;
        nxt[FB_N] = 1'b1;
      end
      default: known = 1'b0;
    endcase
    nxt[FB_X5] = 1'b0;
    nxt[FB_X3] = 1'b0;
  end
endmodule

// File: rtl/fg_bank.sv
module fg_bank #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          swap,
  output logic [DW-1:0] rd_data
);
  localparam int COPIES = 2;

  logic          sel_q;
  logic [DW-1:0] copy_q [COPIES];

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        copy_q[i] <= '0;
      else if (wr_en && (sel_q == i[0]))
        copy_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= 1'b0;
    else if (swap)
      sel_q <= ~sel_q;
  end

  assign rd_data = copy_q[sel_q];
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import fg_pkg::*;
#(
  parameter int W  = 8,
  parameter int HB = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [3:0]   op_class,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] result,
  input  logic         carry_out,
  input  logic         xchg,
  output logic [7:0]   flags
);
  logic [FLAG_W-1:0] cur_flags;
  logic [FLAG_W-1:0] nxt_flags;
  logic              code_known;

  assign op_ready = 1'b1;

  fg_calc #(.W(W), .HB(HB)) u_calc (
    .op    (op_class),
    .a     (opnd_a),
    .b     (opnd_b),
    .r     (result),
    .co    (carry_out),
    .cur   (cur_flags),
    .nxt   (nxt_flags),
    .known (code_known)
  );

  fg_bank #(.DW(FLAG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (op_valid && op_ready && code_known),
    .wr_data (nxt_flags),
    .swap    (xchg),
    .rd_data (cur_flags)
  );

  assign flags = cur_flags;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       op_ready,
  input logic [3:0] op_class,
  input logic [7:0] result,
  input logic       xchg,
  input logic [7:0] flags
);
  logic upd;
  assign upd = op_valid && op_ready && !xchg;

  p_spare_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[5] == 1'b0) && (flags[3] == 1'b0));

  p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op_class <= 4'd7) |=> (flags[6] == ($past(result) == 8'h00)));

  p_and_sets_h_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op_class == 4'd2) |=> flags[4]);

  p_logic_clears_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op_class >= 4'd2 && op_class <= 4'd4) |=> !flags[0]);

  p_incdec_keeps_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (op_class == 4'd5 || op_class == 4'd6)) |=> (flags[0] == $past(flags[0])));

  p_scf_sets_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op_class == 4'd8) |=> (flags[0] && !flags[4] && !flags[1]));

  p_double_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg && !op_valid) ##1 (xchg && !op_valid) |=> (flags == $past(flags, 2)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((!op_valid || op_class > 4'd10) && !xchg) |=> $stable(flags));
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_class (op_class),
  .result   (result),
  .xchg     (xchg),
  .flags    (flags)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [3:0] op_class = 4'd0;
  logic [7:0] opnd_a = 8'h00;
  logic [7:0] opnd_b = 8'h00;
  logic [7:0] result = 8'h00;
  logic       carry_out = 1'b0;
  logic       xchg = 1'b0;
  logic [7:0] flags;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m_act = 8'h00;
  logic [7:0] m_alt = 8'h00;
  int cin = 0;

  always #10 clk = ~clk;

  alu_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_class(op_class), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .carry_out(carry_out), .xchg(xchg), .flags(flags)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h (op %0d a %02h b %02h r %02h)",
               tag, got, exp, op_class, opnd_a, opnd_b, result);
    end
  endtask

  function automatic logic [7:0] model(input int op, input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] r, input logic co, input int ci,
                                       input logic [7:0] old);
    logic [7:0] f;
    int sa;
    int sb;
    int sr;
    f = old;
    sa = $signed(a);
    sb = $signed(b);
    if (op <= 7) begin
      f[7] = r[7];
      f[6] = (r == 8'h00);
    end
    case (op)
      0: begin
        sr = sa + sb + ci;
        f[4] = ((a & 8'h0F) + (b & 8'h0F) + ci) > 15;
        f[2] = (sr > 127) || (sr < -128);
        f[1] = 1'b0; f[0] = co;
      end
      1: begin
        sr = sa - sb - ci;
        f[4] = (a & 8'h0F) < ((b & 8'h0F) + ci);
        f[2] = (sr > 127) || (sr < -128);
        f[1] = 1'b1; f[0] = co;
      end
      2, 3, 4: begin
        f[4] = (op == 2);
        f[2] = ($countones(r) % 2) == 0;
        f[1] = 1'b0; f[0] = 1'b0;
      end
      5: begin
        f[4] = ((a & 8'h0F) == 8'h0F);
        f[2] = (a == 8'h7F);
        f[1] = 1'b0;
      end
      6: begin
        f[4] = ((a & 8'h0F) == 8'h00);
        f[2] = (a == 8'h80);
        f[1] = 1'b1;
      end
      7: begin
        f[4] = 1'b0;
        f[2] = ($countones(r) % 2) == 0;
        f[1] = 1'b0; f[0] = co;
      end
      8: begin f[4] = 1'b0; f[1] = 1'b0; f[0] = 1'b1; end
      9: begin f[4] = old[0]; f[1] = 1'b0; f[0] = ~old[0]; end
      10: begin f[4] = 1'b1; f[1] = 1'b1; end
      default: ;
    endcase
    return f;
  endfunction

  task automatic step(input logic v, input int op, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] r, input logic co, input logic xc, input int ci);
    logic [7:0] upd;
    op_valid = v; op_class = op[3:0]; opnd_a = a; opnd_b = b;
    result = r; carry_out = co; xchg = xc; cin = ci;
    @(posedge clk);
    upd = v ? model(op, a, b, r, co, ci, m_act) : m_act;
    if (xc) begin m_act = m_alt; m_alt = upd; end
    else m_act = upd;
    @(negedge clk);
    op_valid = 1'b0; xchg = 1'b0;
  endtask

  task automatic chk_fields(input int op, input logic v, input logic xc);
    if (!v || op > 10 || xc) begin
      if (xc) chk("R10 swap", flags, m_act);
      else    chk("R11 no change", flags, m_act);
    end else begin
      chk("R2 spare bits", {2'b00, flags[5], 1'b0, flags[3], 3'b000}, 8'h00);
      chk("R3 S/Z", {6'd0, flags[7:6]}, {6'd0, m_act[7:6]});
      if (op == 2 || op == 3 || op == 4 || op == 7) chk("R4 parity", {7'd0, flags[2]}, {7'd0, m_act[2]});
      else chk("R5 overflow", {7'd0, flags[2]}, {7'd0, m_act[2]});
      chk("R6 H", {7'd0, flags[4]}, {7'd0, m_act[4]});
      chk("R7 C", {7'd0, flags[0]}, {7'd0, m_act[0]});
      chk("R8 N", {7'd0, flags[1]}, {7'd0, m_act[1]});
      if (op >= 8) chk("R9 carry ops", flags, m_act);
      chk("R12 latency", flags, m_act);
    end
  endtask

  task automatic rand_step(input int op, input logic v, input logic xc);
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] r;
    logic co;
    int ci;
    logic [8:0] w;
    a = 8'($urandom); b = 8'($urandom);
    ci = int'($urandom % 2); co = 1'($urandom); r = 8'($urandom);
    case (op)
      0: begin w = {1'b0, a} + {1'b0, b} + 9'(ci); r = w[7:0]; co = w[8]; end
      1: begin w = {1'b0, a} - {1'b0, b} - 9'(ci); r = w[7:0]; co = w[8]; end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = a + 8'd1;
      6: r = a - 8'd1;
      default: ;
    endcase
    if (op != 0 && op != 1) ci = 0;
    step(v, op, a, b, r, co, xc, ci);
    chk_fields(op, v, xc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset flags", flags, 8'h00);
    chk("R1 ready", {7'd0, op_ready}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    void'($urandom(32'd1234));

    // R5 R6: 7F+01 -> S,H,PV set
    step(1, 0, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b0, 0);
    chk("R5 add overflow", flags, 8'h94);
    // R7: FF+01 -> Z,H,C
    step(1, 0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0, 0);
    chk("R7 add carry", flags, 8'h51);
    // R7: INC keeps C=1; 7F -> 80
    step(1, 5, 8'h7F, 8'h00, 8'h80, 1'b0, 1'b0, 0);
    chk("R7 inc keeps carry", flags, 8'h95);
    // R6: AND with zero result
    step(1, 2, 8'hF0, 8'h0F, 8'h00, 1'b1, 1'b0, 0);
    chk("R6 and sets H", flags, 8'h54);
    // R9 CCF: C 0 -> 1, H = old C (0)
    step(1, 9, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 0);
    chk("R9 ccf", flags, 8'h45);
    // R9 CPL
    step(1, 10, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 0);
    chk("R9 cpl", flags, 8'h57);
    // R10 swap with simultaneous op: SUB 00-01 written to old active
    step(1, 1, 8'h00, 8'h01, 8'hFF, 1'b1, 1'b1, 0);
    chk("R10 swap shows spare", flags, 8'h00);
    step(0, 0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 0);
    chk("R10 swap back", flags, 8'h93);
    // R11 reserved code
    step(1, 13, 8'hAA, 8'h55, 8'h00, 1'b1, 1'b0, 0);
    chk("R11 reserved code", flags, 8'h93);
    // R4 ROT parity odd result
    step(1, 7, 8'h00, 8'h00, 8'h01, 1'b0, 1'b0, 0);
    chk("R4 rotate parity", flags, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      int op;
      logic v;
      logic xc;
      op = int'($urandom % 16);
      v = ($urandom % 8) != 0;
      xc = ($urandom % 6) == 0;
      rand_step(op, v, xc);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule